// File: doc/BRIEF.md
# Sensor Acquire-Transmit-Sleep Sequencer

This block is the top-level controller of a battery-powered telemetry node. A fast external clock is divided down to a base rate. A 2-bit rate setting then divides that base rate further to give the system clock. The system clock exists only as a one-cycle enable pulse, `sys_tick`. All logic runs on the external clock, so no derived clock ever leaves a flop.

The controller runs the same loop without end. First it powers the sensor front end and lets it settle. Next it steps through four sensor channels, one conversion at a time, and has each result stored in memory. It then hands power over to the transmitter, lets that settle, and clocks out one spread packet. Finally it sleeps for a jumper-selected interval, and the loop starts again.

During the packet the block gates a PN chip clock. Every SYM_DIV chips it produces a symbol tick, and it ends the packet after PKT_LEN symbols. All durations are parameters counted in system ticks. A bench can therefore shrink them without changing any behaviour.

Top module: `telemetry_sequencer`

## Requirements
- R1: With the default prescale of 4, `sys_tick` pulses once every 4·2^`rate_sel` external clocks. `rate_sel` 0, 1, 2 and 3 select divide-by 1, 2, 4 and 8.
- R2: When acquisition begins, `acq_pwr` rises. SETTLE system ticks then pass, and `adc_start` fires on the next tick, which is tick SETTLE+1 counted from the rise.
- R3: Channels are converted in order 0, 1, 2, 3, each with `mux_ch` equal to the channel number during its `adc_start`. The `mem_wr` for a channel pulses on the first system tick after the `adc_done` that ends its conversion, with `mux_ch` still unchanged.
- R4: The system tick that writes channel 3 ends acquisition. On the next clock `acq_pwr` is low and `tx_pwr` is high.
- R5: `pn_en` and `ser_mode` rise once SETTLE system ticks have passed with `tx_pwr` high.
- R6: While `pn_en` is high, `pn_tick` follows `sys_tick`, and `sym_tick` fires on every SYM_DIV-th `pn_tick`. After exactly PKT_LEN symbol ticks, `tx_pwr`, `pn_en` and `ser_mode` fall together.
- R7: At the end of the packet, `sleep_sel` is sampled. Code 0 selects SLP0 ticks (8 s by default), 1 selects SLP1 (1 s), 2 selects SLP2 (0.125 s) and 3 selects SLP3 (zero). `sleeping` stays high for exactly that many system ticks. With a zero length it never rises, and acquisition restarts at once.
- R8: `acq_pwr` and `tx_pwr` are never high together.
- R9: While `rst` is high on a clock edge, all enables, strobes and `sleeping` are low on the next cycle. On the cycle after `rst` is released, acquisition begins.
- R10: An `adc_done` that arrives while no conversion is pending is ignored and causes no `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | System clock divide select (1, 2, 4, 8) |
| sleep_sel | input | 2 | Sleep length select |
| adc_done | input | 1 | Conversion finished, one-cycle pulse |
| sys_tick | output | 1 | System clock enable pulse |
| acq_pwr | output | 1 | Sensor and acquisition power enable |
| mux_ch | output | 2 | Sensor channel select |
| adc_start | output | 1 | Conversion start pulse |
| mem_wr | output | 1 | Memory write strobe for the current channel |
| tx_pwr | output | 1 | Transmitter power enable |
| ser_mode | output | 1 | Serializer in shift mode |
| pn_en | output | 1 | PN chip clock gate |
| pn_tick | output | 1 | Gated PN chip clock pulse |
| sym_tick | output | 1 | Symbol clock pulse, one per SYM_DIV chips |
| sleeping | output | 1 | Sleep interval in progress |

## Verification
Some properties are checked by assertions on every cycle:
- the two power domains are never on together;
- reset silences every output;
- a conversion holds until `adc_done`, and every write is preceded by one;
- the channel advances by one per write;
- symbol ticks occur only inside transmit;
- no counter reaches its limit.

Other properties need the bench's scenarios, which sweep all four divide settings and all four sleep codes:
- the exact settle lengths;
- the chip and symbol totals of a packet;
- the sleep length for each code;
- the spacing between system ticks;
- the rejection of stray `adc_done` pulses during settle, transmit and sleep;
- recovery from a reset in the middle of a packet.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ_SETTLE,
    ST_CH_START,
    ST_CONV,
    ST_WRITE,
    ST_TX_SETTLE,
    ST_TX_SEND,
    ST_SLEEP
  } mode_e;

  // Mask of low rate-counter bits that must all be set for a system tick:
  // divide by 2^sel of the base tick.
  function automatic logic [2:0] rate_mask(input logic [1:0] sel);
    return 3'((4'd1 << sel) - 4'd1);
  endfunction

endpackage

// File: rtl/sys_clk_gen.sv
module sys_clk_gen
  import seq_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  output logic       sys_tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [2:0]    rate_q;
  logic          base_tick;

  assign base_tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst)            pre_q <= '0;
    else if (base_tick) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            rate_q <= '0;
    else if (base_tick) rate_q <= rate_q + 1'b1;
  end

  assign sys_tick = base_tick && ((rate_q & rate_mask(rate_sel)) == rate_mask(rate_sel));

  // R1: the base tick is a single-cycle pulse
  p_base_gap_r1: assert property (@(posedge clk) disable iff (rst)
    base_tick |=> !base_tick);
  // R1: a system tick never lasts two clocks
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    sys_tick |=> !sys_tick);

endmodule

// File: rtl/tick_cnt.sv
module tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (lim != '0) && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= hit ? '0 : cnt + 1'b1;
  end

  // R7 (and R5/R6 timers): a running count stays below its limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (!clr && lim != '0) |-> (cnt < lim));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SLP_W = 24,
  parameter int SLP0  = 7159091,
  parameter int SLP1  = 894886,
  parameter int SLP2  = 111861,
  parameter int SLP3  = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sys_tick,
  input  logic                   adc_done,
  input  logic [1:0]             sleep_sel,
  input  logic                   settle_done,
  input  logic                   pkt_done,
  input  logic                   sleep_done,
  output logic                   acq_pwr,
  output logic                   tx_pwr,
  output logic                   pn_en,
  output logic                   ser_mode,
  output logic                   sleeping,
  output logic                   adc_start,
  output logic                   mem_wr,
  output logic                   settle_run,
  output logic [$clog2(NCH)-1:0] mux_ch,
  output logic [SLP_W-1:0]       sleep_lim
);
  localparam int CH_W = $clog2(NCH);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  mode_e st, nxt;
  logic [CH_W-1:0] ch_q;
  logic last_ch;
  logic [SLP_W-1:0] sleep_req;

  function automatic logic [SLP_W-1:0] sleep_count(input logic [1:0] sel);
    logic [SLP_W-1:0] r;
    case (sel)
      2'd0:    r = SLP_W'(SLP0);
      2'd1:    r = SLP_W'(SLP1);
      2'd2:    r = SLP_W'(SLP2);
      default: r = SLP_W'(SLP3);
    endcase
    return r;
  endfunction

  assign sleep_req = sleep_count(sleep_sel);
  assign last_ch   = (ch_q == CH_LAST);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:       nxt = ST_ACQ_SETTLE;
      ST_ACQ_SETTLE: if (settle_done) nxt = ST_CH_START;
      ST_CH_START:   if (sys_tick)    nxt = ST_CONV;
      ST_CONV:       if (adc_done)    nxt = ST_WRITE;
      ST_WRITE:      if (sys_tick)    nxt = last_ch ? ST_TX_SETTLE : ST_CH_START;
      ST_TX_SETTLE:  if (settle_done) nxt = ST_TX_SEND;
      ST_TX_SEND:    if (pkt_done)    nxt = (sleep_req == '0) ? ST_ACQ_SETTLE : ST_SLEEP;
      ST_SLEEP:      if (sleep_done)  nxt = ST_ACQ_SETTLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                          ch_q <= '0;
    else if (st == ST_WRITE && sys_tick) ch_q <= last_ch ? '0 : ch_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                              sleep_lim <= '0;
    else if (st == ST_TX_SEND && pkt_done) sleep_lim <= sleep_req;
  end

  assign acq_pwr    = (st == ST_ACQ_SETTLE) || (st == ST_CH_START) ||
                      (st == ST_CONV) || (st == ST_WRITE);
  assign tx_pwr     = (st == ST_TX_SETTLE) || (st == ST_TX_SEND);
  assign pn_en      = (st == ST_TX_SEND);
  assign ser_mode   = (st == ST_TX_SEND);
  assign sleeping   = (st == ST_SLEEP);
  assign settle_run = (st == ST_ACQ_SETTLE) || (st == ST_TX_SETTLE);
  assign adc_start  = (st == ST_CH_START) && sys_tick;
  assign mem_wr     = (st == ST_WRITE) && sys_tick;
  assign mux_ch     = ch_q;

  // R10: a pending conversion is not left without a done pulse
  p_conv_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONV && !adc_done) |=> (st == ST_CONV));
  // R10: the write state is entered only behind an accepted done
  p_write_needs_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_WRITE) |-> $past(adc_done));
  // R3: each non-final write moves to the next channel
  p_ch_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !last_ch) |=> (mux_ch == CH_W'($past(mux_ch) + 1'b1)));
  // R4: the final write hands power to the transmitter
  p_acq_to_tx_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && last_ch) |=> (tx_pwr && !acq_pwr));

endmodule

// File: rtl/telemetry_sequencer.sv
module telemetry_sequencer #(
  parameter int PRE_DIV = 4,
  parameter int SETTLE  = 1024,
  parameter int SYM_DIV = 63,
  parameter int PKT_LEN = 65,
  parameter int NCH     = 4,
  parameter int SLP_W   = 24,
  parameter int SLP0    = 7159091,
  parameter int SLP1    = 894886,
  parameter int SLP2    = 111861,
  parameter int SLP3    = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             rate_sel,
  input  logic [1:0]             sleep_sel,
  input  logic                   adc_done,
  output logic                   sys_tick,
  output logic                   acq_pwr,
  output logic [$clog2(NCH)-1:0] mux_ch,
  output logic                   adc_start,
  output logic                   mem_wr,
  output logic                   tx_pwr,
  output logic                   ser_mode,
  output logic                   pn_en,
  output logic                   pn_tick,
  output logic                   sym_tick,
  output logic                   sleeping
);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int SYM_W = $clog2(SYM_DIV + 1);
  localparam int PKT_W = $clog2(PKT_LEN + 1);

  logic settle_run, settle_done, pkt_done, sleep_done;
  logic [SLP_W-1:0] sleep_lim;

  sys_clk_gen #(.PRE_DIV(PRE_DIV)) u_clk (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .sys_tick(sys_tick)
  );

  seq_fsm #(
    .NCH(NCH), .SLP_W(SLP_W),
    .SLP0(SLP0), .SLP1(SLP1), .SLP2(SLP2), .SLP3(SLP3)
  ) u_fsm (
    .clk(clk), .rst(rst), .sys_tick(sys_tick), .adc_done(adc_done),
    .sleep_sel(sleep_sel), .settle_done(settle_done), .pkt_done(pkt_done),
    .sleep_done(sleep_done), .acq_pwr(acq_pwr), .tx_pwr(tx_pwr),
    .pn_en(pn_en), .ser_mode(ser_mode), .sleeping(sleeping),
    .adc_start(adc_start), .mem_wr(mem_wr), .settle_run(settle_run),
    .mux_ch(mux_ch), .sleep_lim(sleep_lim)
  );

  assign pn_tick = sys_tick && pn_en;

  // power-up settle, shared by acquisition and transmit
  tick_cnt #(.W(SET_W)) u_settle (
    .clk(clk), .rst(rst), .clr(!settle_run), .en(sys_tick && settle_run),
    .lim(SET_W'(SETTLE)), .hit(settle_done)
  );

  // chips per symbol
  tick_cnt #(.W(SYM_W)) u_sym (
    .clk(clk), .rst(rst), .clr(!pn_en), .en(pn_tick),
    .lim(SYM_W'(SYM_DIV)), .hit(sym_tick)
  );

  // symbols per packet
  tick_cnt #(.W(PKT_W)) u_pkt (
    .clk(clk), .rst(rst), .clr(!pn_en), .en(sym_tick),
    .lim(PKT_W'(PKT_LEN)), .hit(pkt_done)
  );

  // sleep interval
  tick_cnt #(.W(SLP_W)) u_sleep (
    .clk(clk), .rst(rst), .clr(!sleeping), .en(sys_tick && sleeping),
    .lim(sleep_lim), .hit(sleep_done)
  );

  // R8: the two power domains never overlap
  p_pwr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(acq_pwr && tx_pwr));
  // R9: reset silences every enable and strobe
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!acq_pwr && !tx_pwr && !pn_en && !ser_mode && !sleeping && !adc_start && !mem_wr));
  // R6: symbol ticks appear only while transmitting
  p_sym_in_tx_r6: assert property (@(posedge clk) disable iff (rst)
    sym_tick |-> (pn_tick && tx_pwr));
  // R6: the packet end drops every transmit enable at once
  p_tx_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pn_en) |-> (!tx_pwr && !ser_mode));

endmodule

// File: tb/sim_telemetry_sequencer.sv
module sim_telemetry_sequencer;
  localparam int ST = 6;
  localparam int SD = 3;
  localparam int PL = 5;

  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] slp;
    logic [7:0] period;
    logic [7:0] sleep_ticks;
  } vec_t;

  // rate_sel, sleep_sel, expected clocks per system tick, expected sleep ticks
  localparam vec_t VEC [4] = '{
    '{2'd0, 2'd3, 8'd4,  8'd0},
    '{2'd1, 2'd2, 8'd8,  8'd7},
    '{2'd3, 2'd1, 8'd32, 8'd20},
    '{2'd2, 2'd0, 8'd16, 8'd40}
  };

  logic clk, rst, adc_done;
  logic [1:0] rate_sel, sleep_sel, mux_ch;
  logic sys_tick, acq_pwr, adc_start, mem_wr, tx_pwr, ser_mode, pn_en, pn_tick, sym_tick, sleeping;

  telemetry_sequencer #(
    .SETTLE(ST), .SYM_DIV(SD), .PKT_LEN(PL),
    .SLP0(40), .SLP1(20), .SLP2(7), .SLP3(0)
  ) u0 (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .sleep_sel(sleep_sel), .adc_done(adc_done),
    .sys_tick(sys_tick), .acq_pwr(acq_pwr), .mux_ch(mux_ch), .adc_start(adc_start),
    .mem_wr(mem_wr), .tx_pwr(tx_pwr), .ser_mode(ser_mode), .pn_en(pn_en),
    .pn_tick(pn_tick), .sym_tick(sym_tick), .sleeping(sleeping)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor and ADC model, all at the falling edge
  bit clr_stats, spur_en;
  int clkcnt, period, acq_ticks, m_acq, n_start, n_wr, tsd, conv_cnt;
  int tx_settle, n_pn, n_sym, n_sleep, n_acq_rise;
  bit started, done_ok, pend, pnf_seen, pnf_tx, pnf_ser, tx_rise_acq, p_acq, p_tx, p_pn;
  int start_ch[4], wr_ch[4], wr_ok[4], wr_gap[4];

  always @(negedge clk) begin
    if (rst || clr_stats) begin
      clkcnt = 0; period = 0; acq_ticks = 0; m_acq = 0; n_start = 0; n_wr = 0;
      tsd = 0; conv_cnt = 0; tx_settle = 0; n_pn = 0; n_sym = 0; n_sleep = 0;
      n_acq_rise = 0; started = 0; done_ok = 0; pend = 0; pnf_seen = 0;
      pnf_tx = 1; pnf_ser = 1; tx_rise_acq = 1; p_acq = 0; p_tx = 0; p_pn = 0;
      for (int i = 0; i < 4; i++) begin
        start_ch[i] = -1; wr_ch[i] = -1; wr_ok[i] = 0; wr_gap[i] = -1;
      end
      adc_done = 1'b0;
    end else begin
      clkcnt++;
      if (sys_tick) begin period = clkcnt; clkcnt = 0; end
      if (acq_pwr && !p_acq) begin acq_ticks = 0; started = 0; n_acq_rise++; end
      if (sys_tick && acq_pwr && !started) acq_ticks++;
      if (sys_tick) tsd++;
      if (adc_start) begin
        if (!started) begin started = 1; m_acq = acq_ticks; end
        if (n_start < 4) start_ch[n_start] = int'(mux_ch);
        n_start++; done_ok = 0; conv_cnt = 3; pend = 1;
      end
      if (mem_wr) begin
        if (n_wr < 4) begin wr_ch[n_wr] = int'(mux_ch); wr_ok[n_wr] = int'(done_ok); wr_gap[n_wr] = tsd; end
        n_wr++; done_ok = 0; pend = 0;
      end
      if (tx_pwr && !p_tx) tx_rise_acq = acq_pwr;
      if (sys_tick && tx_pwr && !pn_en) tx_settle++;
      if (pn_tick) n_pn++;
      if (sym_tick) n_sym++;
      if (!pn_en && p_pn) begin pnf_seen = 1; pnf_tx = tx_pwr; pnf_ser = ser_mode; end
      if (sys_tick && sleeping) n_sleep++;
      p_acq = acq_pwr; p_tx = tx_pwr; p_pn = pn_en;
      adc_done = 1'b0;
      if (conv_cnt > 0) begin
        conv_cnt--;
        if (conv_cnt == 0) begin adc_done = 1'b1; done_ok = 1; tsd = 0; end
      end else if (spur_en && !pend && clkcnt[0]) begin
        adc_done = 1'b1;  // stray pulse with no conversion pending (R10)
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst = 1'b1; rate_sel = 2'd0; sleep_sel = 2'd0; clr_stats = 0; spur_en = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 reset enables", int'({acq_pwr, tx_pwr, pn_en, ser_mode, sleeping}), 0);
    chk("R9 reset strobes", int'({adc_start, mem_wr, sys_tick, mux_ch}), 0);

    for (int v = 0; v < 4; v++) begin
      @(posedge clk); #1;
      rst = 1'b1; clr_stats = 1; rate_sel = VEC[v].rate; sleep_sel = VEC[v].slp; spur_en = 1;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0; clr_stats = 0;
      while (n_acq_rise < 2) begin @(negedge clk); #1; end
      chk("R1 tick period", period, int'(VEC[v].period));
      chk("R2 acq settle ticks to start", m_acq, ST + 1);
      chk("R3 start count", n_start, 4);
      chk("R10 write count", n_wr, 4);
      for (int i = 0; i < 4; i++) begin
        chk("R3 start channel", start_ch[i], i);
        chk("R3 write channel", wr_ch[i], i);
        chk("R3 write on first tick after done", wr_gap[i], 1);
        chk("R10 write only after real done", wr_ok[i], 1);
      end
      chk("R4 acq off at tx rise", int'(tx_rise_acq), 0);
      chk("R5 tx settle ticks", tx_settle, ST);
      chk("R6 chip count", n_pn, PL * SD);
      chk("R6 symbol count", n_sym, PL);
      chk("R6 tx enables drop together", int'({pnf_seen, pnf_tx, pnf_ser}), 4);
      chk("R7 sleep ticks", n_sleep, int'(VEC[v].sleep_ticks));
    end

    // directed: reset in the middle of a packet
    while (!pn_en) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 mid-packet reset enables", int'({acq_pwr, tx_pwr, pn_en, ser_mode, sleeping}), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R9 acquisition after release", int'({acq_pwr, tx_pwr}), 2);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule